// File: doc/BRIEF.md
# I2C Slave Byte Receiver with 7-bit and 10-bit Addressing

This block is the receive side of an I2C target. It follows the bus through synchronized copies of SCL and SDA, detects START, repeated START and STOP, shifts in each byte on the rising clock edges, and decides what to do with the byte on the falling edge of its eighth clock. Address bytes are matched against a host-written address register, either as a single 7-bit address or as a two-byte 10-bit address. On a match, the block pulls SDA low during the ninth clock to acknowledge, and it raises an interrupt flag when that ninth clock falls.

A small host register interface sits beside the bus logic. It exposes the receive buffer and several flags: buffer full, overflow, address update pending, read/write direction and interrupt. The host clears these flags with one-cycle strobes and writes the address register. While a 10-bit address is being received, the block holds SCL low after each address byte until the host has loaded the next half of the address. That is the only point at which the block stretches the clock.

Top module: `i2c_rx10`

## Requirements
- R1: While `en` is low the block drives neither line and ignores START. With `en` high it ignores clocked bytes until a START condition (SDA falling while SCL is high) has been seen.
- R2: In 7-bit mode (`mode10`=0) the first byte after START matches when its bits [7:1] equal `addr_q[7:1]`. On a match SDA is pulled low through the ninth clock. On a mismatch SDA stays released, no flag changes, and later bytes are ignored until the next START.
- R3: For a matched address byte or a data byte with buffer full and overflow both clear, the byte is written into `rx_data` and `buf_full` rises at the eighth falling SCL edge. SDA is pulled low for the acknowledge, and `rx_irq` rises at the ninth falling SCL edge.
- R4: A byte received while `buf_full`=1 leaves `rx_data` unchanged, is not acknowledged, sets `rx_ovf` and sets `rx_irq`.
- R5: A byte received with `buf_full`=0 and `rx_ovf`=1 is loaded into `rx_data` and sets `buf_full` and `rx_irq`, but it is not acknowledged.
- R6: Bit 0 of a matched first address byte is stored in `rw_read`, and the address byte itself is placed in `rx_data`. After an acknowledged address with bit 0 = 1, the block releases the bus and waits for the next START.
- R7: In 10-bit mode the first address byte must have bits [7:3] = 11110, bits [2:1] equal to `addr_q[2:1]` (the two top address bits) and bit 0 = 0. After it is acknowledged, `addr_upd` is set at the ninth falling edge and SCL is held low until the host writes the address register, which clears `addr_upd`.
- R8: In 10-bit mode the second address byte matches when all 8 bits equal `addr_q`. It sets `addr_upd` and holds SCL in the same way as R7. Later bytes are data bytes.
- R9: Once a full 10-bit address has matched, a repeated START followed by a first address byte that matches is enough, with bit 0 either value. This sets neither `addr_upd` nor the clock hold.
- R10: A STOP returns the block to idle and forgets a completed 10-bit match. A first address byte with bit 0 = 1 is then not acknowledged.
- R11: `rd_buf` clears `buf_full`, `clr_irq` clears `rx_irq` and `clr_ovf` clears `rx_ovf`. When a hardware set and a host clear fall in the same cycle, the set wins.
- R12: After reset all flags and `rx_data` are zero, `addr_q` is zero and neither line is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Receiver enable |
| mode10 | input | 1 | 1 selects 10-bit addressing, 0 selects 7-bit |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_drive_low | output | 1 | Open-drain pull-down for SCL (clock hold) |
| sda_drive_low | output | 1 | Open-drain pull-down for SDA (acknowledge) |
| rd_buf | input | 1 | Host strobe: buffer read, clears buf_full |
| clr_irq | input | 1 | Host strobe: clears rx_irq |
| clr_ovf | input | 1 | Host strobe: clears rx_ovf |
| addr_wr | input | 1 | Host strobe: write addr_wdata to the address register |
| addr_wdata | input | 8 | Address register write data |
| rx_data | output | 8 | Receive buffer |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| rx_ovf | output | 1 | Overflow flag |
| rx_irq | output | 1 | Interrupt flag |
| addr_upd | output | 1 | Address register update pending (SCL held) |
| rw_read | output | 1 | Direction bit of the last matched address |

## Verification
The set of `buf_full` at the eighth falling edge can meet a host buffer read in the same cycle. The set of `rx_irq` at the ninth falling edge can meet a host interrupt clear in the same cycle. The bench counts the synchronizer and edge-detect registers so that it places the host strobe exactly in the cycle where the falling SCL edge takes effect. It then expects both flags to remain set, with the newly received byte in the buffer. A reference model of the flags, written from the requirements, is compared with the outputs on every clock outside short settling windows. This comparison shows whether a host clear has ever overridden a hardware set.

// File: rtl/i2c_rx10_pkg.sv
package i2c_rx10_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned CNT_W   = $clog2(BYTE_W + 1);
    localparam logic [4:0]  HDR10   = 5'b11110;

    typedef enum logic [1:0] {
        PH_WAIT = 2'd0,
        PH_BITS = 2'd1,
        PH_ACK  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        RL_HI   = 2'd0,
        RL_LO   = 2'd1,
        RL_DATA = 2'd2
    } role_e;

    typedef struct packed {
        logic  matched;
        logic  ack;
        logic  load;
        logic  set_ovf;
        logic  set_upd;
        logic  go_wait;
        role_e nxt_role;
    } byte_dec_t;

    function automatic logic is_hdr10(input logic [BYTE_W-1:0] b);
        return b[BYTE_W-1 -: 5] == HDR10;
    endfunction

endpackage

// File: rtl/i2c_rx10_sync.sv
module i2c_rx10_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_s,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic              scl_prev, sda_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff   <= '1;
            sda_ff   <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_ff   <= {scl_ff[STAGES-2:0], scl_in};
            sda_ff   <= {sda_ff[STAGES-2:0], sda_in};
            scl_prev <= scl_ff[STAGES-1];
            sda_prev <= sda_ff[STAGES-1];
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign scl_rise  = scl_s & ~scl_prev;
    assign scl_fall  = ~scl_s & scl_prev;
    assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/i2c_rx10_shift.sv
module i2c_rx10_shift
    import i2c_rx10_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              restart,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    output logic [BYTE_W-1:0] shreg,
    output logic              byte_end
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            shreg <= '0;
        end else if (!run || restart) begin
            cnt <= '0;
        end else if (scl_rise && cnt < CNT_W'(BYTE_W)) begin
            shreg <= {shreg[BYTE_W-2:0], sda_s};
            cnt   <= cnt + 1'b1;
        end
    end

    assign byte_end = run & ~restart & scl_fall & (cnt == CNT_W'(BYTE_W));
endmodule

// File: rtl/i2c_rx10_ctrl.sv
module i2c_rx10_ctrl
    import i2c_rx10_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              mode10,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              scl_fall,
    input  logic              byte_end,
    input  logic [BYTE_W-1:0] shreg,
    input  logic              rd_buf,
    input  logic              clr_irq,
    input  logic              clr_ovf,
    input  logic              addr_wr,
    input  logic [BYTE_W-1:0] addr_wdata,
    output logic              run,
    output logic              ack_drive,
    output logic [BYTE_W-1:0] rx_data,
    output logic              buf_full,
    output logic              rx_ovf,
    output logic              rx_irq,
    output logic              addr_upd,
    output logic              rw_read
);
    phase_e            phase_q;
    role_e             role_q, nxt_role_q;
    logic              m10_q, pend_upd_q, pend_wait_q;
    logic [BYTE_W-1:0] addr_q;
    byte_dec_t         dec;
    logic              hi_match;

    // First-byte compare: bits [7:1] always; 10-bit mode adds header and
    // requires a write unless a full 10-bit match is already on record.
    always_comb begin
        hi_match = (shreg[BYTE_W-1:1] == addr_q[BYTE_W-1:1]);
        if (mode10)
            hi_match = hi_match & is_hdr10(shreg) & (~shreg[0] | m10_q);
    end

    always_comb begin
        dec = '0;
        dec.nxt_role = RL_DATA;
        unique case (role_q)
            RL_HI:   dec.matched = hi_match;
            RL_LO:   dec.matched = (shreg == addr_q);
            default: dec.matched = 1'b1;
        endcase
        dec.ack     = dec.matched & ~buf_full & ~rx_ovf;
        dec.load    = dec.matched & ~buf_full;
        dec.set_ovf = dec.matched & buf_full;
        dec.set_upd = dec.ack & mode10 &
                      (((role_q == RL_HI) & ~m10_q) | (role_q == RL_LO));
        if (role_q == RL_DATA)
            dec.go_wait = 1'b0;
        else if (!dec.ack)
            dec.go_wait = 1'b1;
        else if (role_q == RL_LO)
            dec.nxt_role = RL_DATA;
        else if (mode10 && !m10_q)
            dec.nxt_role = RL_LO;
        else
            dec.go_wait = shreg[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_WAIT;
            role_q      <= RL_HI;
            nxt_role_q  <= RL_HI;
            m10_q       <= 1'b0;
            pend_upd_q  <= 1'b0;
            pend_wait_q <= 1'b0;
            addr_q      <= '0;
            ack_drive   <= 1'b0;
            rx_data     <= '0;
            buf_full    <= 1'b0;
            rx_ovf      <= 1'b0;
            rx_irq      <= 1'b0;
            addr_upd    <= 1'b0;
            rw_read     <= 1'b0;
        end else begin
            // host side first, so that hardware sets below take priority
            if (rd_buf)  buf_full <= 1'b0;
            if (clr_irq) rx_irq   <= 1'b0;
            if (clr_ovf) rx_ovf   <= 1'b0;
            if (addr_wr) begin
                addr_q   <= addr_wdata;
                addr_upd <= 1'b0;
            end

            if (!en) begin
                phase_q   <= PH_WAIT;
                ack_drive <= 1'b0;
                m10_q     <= 1'b0;
                addr_upd  <= 1'b0;
            end else if (start_det) begin
                phase_q   <= PH_BITS;
                role_q    <= RL_HI;
                ack_drive <= 1'b0;
            end else if (stop_det) begin
                phase_q   <= PH_WAIT;
                ack_drive <= 1'b0;
                m10_q     <= 1'b0;
            end else begin
                unique case (phase_q)
                    PH_BITS: if (byte_end) begin
                        if (!dec.matched) begin
                            phase_q <= PH_WAIT;
                        end else begin
                            phase_q     <= PH_ACK;
                            ack_drive   <= dec.ack;
                            buf_full    <= 1'b1;
                            pend_upd_q  <= dec.set_upd;
                            pend_wait_q <= dec.go_wait;
                            nxt_role_q  <= dec.nxt_role;
                            if (dec.load)    rx_data <= shreg;
                            if (dec.set_ovf) rx_ovf  <= 1'b1;
                            if (role_q == RL_HI) rw_read <= shreg[0];
                            if (role_q == RL_LO && dec.ack) m10_q <= 1'b1;
                        end
                    end
                    PH_ACK: if (scl_fall) begin
                        ack_drive <= 1'b0;
                        rx_irq    <= 1'b1;
                        if (pend_upd_q) addr_upd <= 1'b1;
                        phase_q   <= pend_wait_q ? PH_WAIT : PH_BITS;
                        role_q    <= nxt_role_q;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign run = (phase_q == PH_BITS);
endmodule

// File: rtl/i2c_rx10.sv
module i2c_rx10
    import i2c_rx10_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              mode10,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    input  logic              rd_buf,
    input  logic              clr_irq,
    input  logic              clr_ovf,
    input  logic              addr_wr,
    input  logic [BYTE_W-1:0] addr_wdata,
    output logic [BYTE_W-1:0] rx_data,
    output logic              buf_full,
    output logic              rx_ovf,
    output logic              rx_irq,
    output logic              addr_upd,
    output logic              rw_read
);
    logic scl_s, scl_rise, scl_fall, sda_s, start_det, stop_det;
    logic run, byte_end;
    logic [BYTE_W-1:0] shreg;

    i2c_rx10_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_i), .sda_in(sda_i),
        .scl_s(scl_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det)
    );

    i2c_rx10_shift u_shift (
        .clk(clk), .rst(rst), .run(run), .restart(start_det),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
        .shreg(shreg), .byte_end(byte_end)
    );

    i2c_rx10_ctrl u_ctrl (
        .clk(clk), .rst(rst), .en(en), .mode10(mode10),
        .start_det(start_det), .stop_det(stop_det), .scl_fall(scl_fall),
        .byte_end(byte_end), .shreg(shreg),
        .rd_buf(rd_buf), .clr_irq(clr_irq), .clr_ovf(clr_ovf),
        .addr_wr(addr_wr), .addr_wdata(addr_wdata),
        .run(run), .ack_drive(sda_drive_low), .rx_data(rx_data),
        .buf_full(buf_full), .rx_ovf(rx_ovf), .rx_irq(rx_irq),
        .addr_upd(addr_upd), .rw_read(rw_read)
    );

    // clock hold lasts exactly as long as an address update is pending
    assign scl_drive_low = addr_upd;
endmodule

// File: rtl/i2c_rx10_chk.sv
module i2c_rx10_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic rd_buf,
    input logic clr_irq,
    input logic addr_wr,
    input logic sda_drive_low,
    input logic scl_drive_low,
    input logic buf_full,
    input logic rx_ovf,
    input logic rx_irq,
    input logic addr_upd,
    input logic byte_end,
    input logic scl_s
);
    // R1: a disabled block releases both lines
    a_r1_quiet_disabled: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!sda_drive_low && !scl_drive_low));

    // R2: acknowledge only begins while SCL is low
    a_r2_ack_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_drive_low) |-> !scl_s);

    // R3: an acknowledged byte always leaves the buffer full
    a_r3_ack_fills: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_drive_low) |-> buf_full);

    // R4: no acknowledge when the overflow condition was present
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_drive_low) |-> (!$past(buf_full) && !$past(rx_ovf)));

    // R7: address write ends the pending update and the clock hold
    a_r7_write_releases: assert property (@(posedge clk) disable iff (rst)
        (addr_upd && addr_wr) |=> (!addr_upd && !scl_drive_low));

    // R11: buffer read clears full when no byte completes in that cycle
    a_r11_rd_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_buf && !byte_end) |=> !buf_full);

    // R11: interrupt flag only falls on a host clear
    a_r11_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (rx_irq && !clr_irq) |=> rx_irq);
endmodule

bind i2c_rx10 i2c_rx10_chk u_chk (
    .clk(clk), .rst(rst), .en(en), .rd_buf(rd_buf), .clr_irq(clr_irq),
    .addr_wr(addr_wr), .sda_drive_low(sda_drive_low),
    .scl_drive_low(scl_drive_low), .buf_full(buf_full), .rx_ovf(rx_ovf),
    .rx_irq(rx_irq), .addr_upd(addr_upd), .byte_end(byte_end),
    .scl_s(scl_s)
);

// File: tb/i2c_rx10_tb.sv
module i2c_rx10_tb;
    localparam int HALF = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst, en, mode10, tb_scl_low, tb_sda_low;
    logic       rd_buf, clr_irq, clr_ovf, addr_wr;
    logic [7:0] addr_wdata;
    logic       scl_drive_low, sda_drive_low;
    logic [7:0] rx_data;
    logic       buf_full, rx_ovf, rx_irq, addr_upd, rw_read;
    logic       scl_line, sda_line;

    assign scl_line = !(tb_scl_low || scl_drive_low);
    assign sda_line = !(tb_sda_low || sda_drive_low);

    i2c_rx10 u_dut (
        .clk(clk), .rst(rst), .en(en), .mode10(mode10),
        .scl_i(scl_line), .sda_i(sda_line),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .rd_buf(rd_buf), .clr_irq(clr_irq), .clr_ovf(clr_ovf),
        .addr_wr(addr_wr), .addr_wdata(addr_wdata),
        .rx_data(rx_data), .buf_full(buf_full), .rx_ovf(rx_ovf),
        .rx_irq(rx_irq), .addr_upd(addr_upd), .rw_read(rw_read)
    );

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;

    // reference model: roles 0 idle, 1 first address, 2 second address, 3 data
    logic [7:0] m_addr, m_buf;
    bit m_bf, m_ovf, m_irq, m_ua, m_rw, m_m10, m_ack, m_pirq, m_pua;
    int m_role, m_next;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (cmp_en) begin
            chk("R3 buf_full", buf_full, m_bf);
            chk("R3 rx_data", rx_data, m_buf);
            chk("R3 rx_irq", rx_irq, m_irq);
            chk("R4 rx_ovf", rx_ovf, m_ovf);
            chk("R7 addr_upd", addr_upd, m_ua);
            chk("R7 scl hold", scl_drive_low, m_ua);
            chk("R6 rw_read", rw_read, m_rw);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_byte(input logic [7:0] b);
        bit match;
        m_ack = 0; m_pirq = 0; m_pua = 0;
        case (m_role)
            1: begin
                match = (b[7:1] == m_addr[7:1]);
                if (mode10) match = match && (b[7:3] == 5'b11110) && (!b[0] || m_m10);
            end
            2: match = (b == m_addr);
            3: match = 1;
            default: match = 0;
        endcase
        if (!match) begin
            m_role = 0;
            return;
        end
        m_ack = !m_bf && !m_ovf;
        if (!m_bf) m_buf = b; else m_ovf = 1;
        m_bf = 1;
        m_pirq = 1;
        if (m_role == 1) m_rw = b[0];
        m_pua = m_ack && mode10 && ((m_role == 1 && !m_m10) || m_role == 2);
        if (m_role == 3) m_next = 3;
        else if (!m_ack) m_next = 0;
        else if (m_role == 2) begin m_m10 = 1; m_next = 3; end
        else if (mode10 && !m_m10) m_next = 2;
        else m_next = b[0] ? 0 : 3;
    endtask

    task automatic model_ninth();
        if (m_pirq) begin
            m_irq = 1;
            if (m_pua) m_ua = 1;
            m_role = m_next;
        end
        m_pirq = 0;
    endtask

    task automatic host(input bit rd, input bit ci, input bit co, input bit aw, input logic [7:0] d);
        @(negedge clk);
        cmp_en = 0;
        rd_buf = rd; clr_irq = ci; clr_ovf = co; addr_wr = aw; addr_wdata = d;
        if (rd) m_bf = 0;
        if (ci) m_irq = 0;
        if (co) m_ovf = 0;
        if (aw) begin m_addr = d; m_ua = 0; end
        @(negedge clk);
        rd_buf = 0; clr_irq = 0; clr_ovf = 0; addr_wr = 0;
        tick(1);
        cmp_en = 1;
    endtask

    task automatic bus_start();
        @(negedge clk);
        tb_sda_low = 0;
        tick(HALF);
        tb_scl_low = 0;
        wait (scl_line === 1'b1);
        tick(HALF);
        cmp_en = 0;
        tb_sda_low = 1;
        m_role = en ? 1 : 0;
        tick(HALF);
        tb_scl_low = 1;
        tick(5);
        cmp_en = 1;
    endtask

    task automatic bus_stop();
        @(negedge clk);
        tb_sda_low = 1;
        tick(HALF);
        tb_scl_low = 0;
        wait (scl_line === 1'b1);
        tick(HALF);
        tb_sda_low = 0;
        m_role = 0;
        m_m10 = 0;
        tick(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit rd8, input bit clr9, input string tag);
        bit acked;
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            tb_sda_low = !b[i];
            tick(HALF);
            tb_scl_low = 0;
            wait (scl_line === 1'b1);
            tick(HALF);
            if (i == 0) begin
                cmp_en = 0;
                tb_scl_low = 1;
                tb_sda_low = 0;
                model_byte(b);
                tick(2);
                rd_buf = rd8;
                tick(1);
                rd_buf = 0;
                tick(3);
                cmp_en = 1;
            end else begin
                tb_scl_low = 1;
            end
        end
        tick(HALF);
        tb_scl_low = 0;
        wait (scl_line === 1'b1);
        tick(HALF / 2);
        acked = !sda_line;
        chk({tag, " ack"}, acked, m_ack);
        tick(HALF / 2);
        cmp_en = 0;
        tb_scl_low = 1;
        model_ninth();
        tick(2);
        clr_irq = clr9;
        tick(1);
        clr_irq = 0;
        tick(3);
        cmp_en = 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; en = 0; mode10 = 0; tb_scl_low = 0; tb_sda_low = 0;
        rd_buf = 0; clr_irq = 0; clr_ovf = 0; addr_wr = 0; addr_wdata = 8'h00;
        m_addr = 0; m_buf = 0; m_bf = 0; m_ovf = 0; m_irq = 0; m_ua = 0;
        m_rw = 0; m_m10 = 0; m_ack = 0; m_pirq = 0; m_pua = 0; m_role = 0; m_next = 0;
        tick(5);
        rst = 0;
        tick(2);
        // R12 reset state
        chk("R12 rx_data", rx_data, 8'h00);
        chk("R12 buf_full", buf_full, 0);
        chk("R12 rx_ovf", rx_ovf, 0);
        chk("R12 rx_irq", rx_irq, 0);
        chk("R12 addr_upd", addr_upd, 0);
        chk("R12 rw_read", rw_read, 0);
        chk("R12 sda released", sda_drive_low, 0);
        chk("R12 scl released", scl_drive_low, 0);
        cmp_en = 1;

        host(0, 0, 0, 1, 8'h5A);
        // R1: disabled, then enabled but no START
        bus_start();
        send_byte(8'h5A, 0, 0, "R1 disabled");
        bus_stop();
        en = 1;
        tick(4);
        send_byte(8'h5A, 0, 0, "R1 no start");
        bus_stop();

        // R2: mismatch, following bytes ignored
        bus_start();
        send_byte(8'h5C, 0, 0, "R2 mismatch");
        send_byte(8'h11, 0, 0, "R2 ignored after mismatch");
        bus_stop();

        // R2/R3/R4/R5/R6 write transfer
        bus_start();
        send_byte(8'h5A, 0, 0, "R2 match");
        chk("R6 address in buffer", rx_data, 8'h5A);
        host(1, 1, 0, 0, 8'h00);
        send_byte(8'h3C, 0, 0, "R3 data");
        send_byte(8'h77, 0, 0, "R4 full");
        chk("R4 buffer kept", rx_data, 8'h3C);
        chk("R4 overflow set", rx_ovf, 1);
        host(1, 0, 0, 0, 8'h00);
        send_byte(8'h88, 0, 0, "R5 overflow only");
        chk("R5 loaded while overflow", rx_data, 8'h88);
        host(1, 1, 1, 0, 8'h00);
        bus_stop();

        // R6 read direction
        bus_start();
        send_byte(8'h5B, 0, 0, "R6 read address");
        chk("R6 rw_read set", rw_read, 1);
        host(1, 1, 0, 0, 8'h00);
        send_byte(8'h99, 0, 0, "R6 released after read");
        bus_stop();

        // R7/R8/R9 10-bit address 0x2A5
        mode10 = 1;
        host(0, 0, 0, 1, 8'hF4);
        bus_start();
        send_byte(8'hF4, 0, 0, "R7 high byte");
        tick(20);
        chk("R7 scl line held", scl_line, 0);
        host(1, 1, 0, 0, 8'h00);
        host(0, 0, 0, 1, 8'hA5);
        chk("R7 scl released", scl_drive_low, 0);
        send_byte(8'hA5, 0, 0, "R8 low byte");
        chk("R8 update pending", addr_upd, 1);
        host(1, 1, 0, 0, 8'h00);
        host(0, 0, 0, 1, 8'hF4);
        send_byte(8'h42, 0, 0, "R8 data after address");
        chk("R8 no hold on data", addr_upd, 0);
        host(1, 1, 0, 0, 8'h00);
        bus_start();
        send_byte(8'hF5, 0, 0, "R9 repeated read");
        chk("R9 no update", addr_upd, 0);
        chk("R9 rw_read", rw_read, 1);
        host(1, 1, 0, 0, 8'h00);
        bus_start();
        send_byte(8'hF4, 0, 0, "R9 repeated write");
        host(1, 1, 0, 0, 8'h00);
        send_byte(8'h24, 0, 0, "R9 data");
        chk("R9 data value", rx_data, 8'h24);
        host(1, 1, 0, 0, 8'h00);
        bus_stop();

        // R10 STOP forgets the match; R7 wrong top bits; R8 low mismatch
        bus_start();
        send_byte(8'hF5, 0, 0, "R10 read without match");
        bus_stop();
        bus_start();
        send_byte(8'hF6, 0, 0, "R7 wrong top bits");
        bus_stop();
        bus_start();
        send_byte(8'hF4, 0, 0, "R7 high again");
        host(1, 1, 0, 0, 8'h00);
        host(0, 0, 0, 1, 8'hA5);
        send_byte(8'hA6, 0, 0, "R8 low mismatch");
        bus_stop();

        // R11 same-cycle set and clear
        mode10 = 0;
        host(0, 0, 0, 1, 8'h5A);
        bus_start();
        send_byte(8'h5A, 0, 0, "R11 address");
        host(1, 0, 0, 0, 8'h00);
        send_byte(8'h61, 1, 1, "R11 collision byte");
        chk("R11 buf_full set wins", buf_full, 1);
        chk("R11 irq set wins", rx_irq, 1);
        chk("R11 collision data", rx_data, 8'h61);
        host(0, 1, 0, 0, 8'h00);
        chk("R11 irq cleared", rx_irq, 0);
        host(1, 0, 0, 0, 8'h00);
        chk("R11 buf_full cleared", buf_full, 0);
        bus_stop();
        tick(10);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule